// File: doc/BRIEF.md
# PHY Bring-Up and Autonegotiation Sequencer

This block walks an Ethernet PHY through a fixed power-on script by issuing register reads and writes to a separate management-bus master. After a `start` pulse it resets the PHY and waits for the reset to clear. It then masks every PHY interrupt and reads the ability register. From the abilities it builds and writes the advertisement word, restarts autonegotiation, and polls until negotiation completes. A remote fault seen during polling triggers a forced restart. Serial signalling on the management wires is left to the master; this block only sees a request channel and a response strobe.

The request channel is valid/ready. Once `req_valid` rises, the sequencer holds `req_write`, `req_addr` and `req_wdata` unchanged until it samples `req_ready` high on a clock edge, and only one request is ever outstanding. A write is finished when it is accepted. A read is finished by the first `rsp_valid` pulse after its acceptance, and `rsp_rdata` is taken in that cycle. The response side has no back-pressure; any `rsp_valid` that arrives while no read is outstanding is ignored.

A `tick` input stands for the half-second pause between polls. Status comes out as a one-cycle `done` pulse plus two sticky flags, `failed` and `timeout`, which hold until the next accepted start.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `req_valid`, `done`, `failed` and `timeout` are low. The first request after an accepted `start` is a write to register 0 with data 0x8000 (only bit 15, the PHY reset bit, set).
- R2: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` stay unchanged. After an acceptance, `req_valid` is low for at least one cycle. A read finishes only on an `rsp_valid` that comes after its acceptance. Read requests carry write data 0.
- R3: Reset completion is polled by reading register 0. The first read follows the reset write directly. If bit 15 reads 0, the sequence proceeds, including on the sixth read.
- R4: If six reads of register 0 all show bit 15 set, the sequencer pulses `done`, sets `timeout` and leaves `failed` low.
- R5: After reset completes, the sequencer writes 0xFFFF to register 18 and then reads register 1 to obtain the abilities.
- R6: The sequencer writes the advertisement to register 4. Bits 4:0 are always 00001. Ability bits 15, 14, 13, 12 and 11 of register 1 (T4, 100 full, 100 half, 10 full, 10 half) are copied to advertisement bits 9, 8, 7, 6 and 5. All other bits are 0.
- R7: The sequencer then writes 0x1200 to register 0 (enable bit 12 and restart bit 9).
- R8: Completion is polled by reading register 1. The first read follows the restart write directly. When bit 5 (complete) reads 1, the sequencer pulses `done`, and `failed` takes the value of bit 4 (remote fault) from that same read.
- R9: When a poll read shows bit 5 clear and bit 4 set, and polls remain, the sequencer writes 0x3300 to register 0 (enable, restart, speed bit 13, duplex bit 8) before it waits for the next poll.
- R10: If twenty reads of register 1 all show bit 5 clear, the sequencer pulses `done` and sets `failed`, whatever bit 4 shows.
- R11: Between two poll reads the sequencer waits for a `tick`. A `tick` received in any other state has no effect.
- R12: `done` is high for exactly one cycle per run. `failed` and `timeout` change only at that pulse or when an accepted `start` clears them.
- R13: A `start` that arrives while a run is in progress has no effect on requests or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| tick | input | 1 | Poll-interval strobe |
| req_valid | output | 1 | Management request pending |
| req_ready | input | 1 | Master accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW (5) | PHY register number |
| req_wdata | output | DW (16) | Write data, 0 on reads |
| rsp_valid | input | 1 | Read data strobe |
| rsp_rdata | input | DW (16) | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| failed | output | 1 | Negotiation failed or ended with remote fault |
| timeout | output | 1 | PHY reset never cleared |

## Verification
A behavioural model in the bench replays the script and predicts every output in every cycle. Runs use different ready delays, response delays and tick spacings, so that handshake timing is separated from script order. The reset-poll cases compare early clearing, clearing on the sixth read, and never clearing, which pins down the poll limit exactly. The negotiation cases cover clean completion, a remote fault followed by recovery, completion with remote fault still set, and twenty polls without completion; together they separate the recovery write from the failure rules. Stray response strobes and repeated starts are injected to show that both are ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  // PHY register numbers
  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_ADV   = 4;
  localparam int REG_IMASK = 18;

  // control register bits
  localparam int CTRL_RESET   = 15;
  localparam int CTRL_SPEED   = 13;
  localparam int CTRL_AN_EN   = 12;
  localparam int CTRL_AN_RST  = 9;
  localparam int CTRL_DUPLEX  = 8;

  // status register bits
  localparam int STAT_AN_DONE = 5;
  localparam int STAT_RFAULT  = 4;
  localparam int STAT_ABIL_LO = 11;

  // advertisement layout
  localparam int N_ABIL       = 5;
  localparam int ADV_ABIL_LO  = 5;
  localparam int SEL_W        = 5;
  localparam logic [SEL_W-1:0] SEL_CSMA = 5'b00001;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_WR, ST_RST_RD, ST_RST_WAIT, ST_MASK_WR, ST_CAP_RD,
    ST_ADV_WR, ST_ANEG_WR, ST_AN_RD, ST_RF_WR, ST_AN_WAIT
  } seq_state_e;
endpackage

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_write,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  output logic          op_done
);
  logic pend_q, wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      wait_q    <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (!pend_q && !wait_q) begin
      if (go) begin
        pend_q    <= 1'b1;
        req_write <= go_write;
        req_addr  <= go_addr;
        req_wdata <= go_write ? go_wdata : '0;
      end
    end else if (pend_q) begin
      if (req_ready) begin
        pend_q <= 1'b0;
        wait_q <= !req_write;
      end
    end else if (rsp_valid) begin
      wait_q <= 1'b0;
    end
  end

  assign req_valid = pend_q;
  assign op_done   = (pend_q && req_ready && req_write) || (wait_q && rsp_valid);
endmodule

// File: rtl/phy_adv_map.sv
module phy_adv_map
  import phy_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [N_ABIL-1:0] abil,
  output logic [DW-1:0]     adv_word
);
  logic [N_ABIL-1:0] adv_bits;

  for (genvar i = 0; i < N_ABIL; i++) begin : g_abil
    assign adv_bits[i] = abil[i];
  end

  always_comb begin
    adv_word = '0;
    adv_word[SEL_W-1:0] = SEL_CSMA;
    adv_word[ADV_ABIL_LO +: N_ABIL] = adv_bits;
  end
endmodule

// File: rtl/phy_poll_ctr.sv
module phy_poll_ctr #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int RST_POLLS = 6,
  parameter int AN_POLLS  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          done,
  output logic          failed,
  output logic          timeout
);
  localparam logic [DW-1:0] W_RESET   = DW'(1) << CTRL_RESET;
  localparam logic [DW-1:0] W_RESTART = (DW'(1) << CTRL_AN_EN) | (DW'(1) << CTRL_AN_RST);
  localparam logic [DW-1:0] W_FORCE   = W_RESTART | (DW'(1) << CTRL_SPEED) | (DW'(1) << CTRL_DUPLEX);
  localparam logic [DW-1:0] W_MASKALL = '1;

  seq_state_e state_q;
  logic [N_ABIL-1:0] caps_q;
  logic [DW-1:0] adv_word, go_wdata;
  logic [AW-1:0] go_addr;
  logic go, go_write, op_done;
  logic rst_last, an_last, begin_run, rst_inc, an_inc;
  logic done_q, failed_q, tmo_q;
  logic rd_reset, rd_an_done, rd_rfault;
  logic unused_rd;

  assign rd_reset   = rsp_rdata[CTRL_RESET];
  assign rd_an_done = rsp_rdata[STAT_AN_DONE];
  assign rd_rfault  = rsp_rdata[STAT_RFAULT];
  assign unused_rd  = ^rsp_rdata;

  assign begin_run = (state_q == ST_IDLE) && start;
  assign rst_inc   = (state_q == ST_RST_RD) && op_done && rd_reset && !rst_last;
  assign an_inc    = (state_q == ST_AN_RD) && op_done && !rd_an_done && !an_last;

  always_comb begin
    go       = 1'b1;
    go_write = 1'b1;
    go_addr  = AW'(REG_CTRL);
    go_wdata = '0;
    unique case (state_q)
      ST_RST_WR:  go_wdata = W_RESET;
      ST_RST_RD:  go_write = 1'b0;
      ST_MASK_WR: begin go_addr = AW'(REG_IMASK); go_wdata = W_MASKALL; end
      ST_CAP_RD:  begin go_addr = AW'(REG_STAT); go_write = 1'b0; end
      ST_ADV_WR:  begin go_addr = AW'(REG_ADV); go_wdata = adv_word; end
      ST_ANEG_WR: go_wdata = W_RESTART;
      ST_AN_RD:   begin go_addr = AW'(REG_STAT); go_write = 1'b0; end
      ST_RF_WR:   go_wdata = W_FORCE;
      default:    go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      caps_q   <= '0;
      done_q   <= 1'b0;
      failed_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_RST_WR;
          failed_q <= 1'b0;
          tmo_q    <= 1'b0;
        end
        ST_RST_WR:  if (op_done) state_q <= ST_RST_RD;
        ST_RST_RD:  if (op_done) begin
          if (!rd_reset)     state_q <= ST_MASK_WR;
          else if (rst_last) begin
            state_q <= ST_IDLE;
            tmo_q   <= 1'b1;
            done_q  <= 1'b1;
          end else           state_q <= ST_RST_WAIT;
        end
        ST_RST_WAIT: if (tick)    state_q <= ST_RST_RD;
        ST_MASK_WR:  if (op_done) state_q <= ST_CAP_RD;
        ST_CAP_RD:   if (op_done) begin
          caps_q  <= rsp_rdata[STAT_ABIL_LO +: N_ABIL];
          state_q <= ST_ADV_WR;
        end
        ST_ADV_WR:   if (op_done) state_q <= ST_ANEG_WR;
        ST_ANEG_WR:  if (op_done) state_q <= ST_AN_RD;
        ST_AN_RD:    if (op_done) begin
          if (rd_an_done) begin
            state_q  <= ST_IDLE;
            failed_q <= rd_rfault;
            done_q   <= 1'b1;
          end else if (an_last) begin
            state_q  <= ST_IDLE;
            failed_q <= 1'b1;
            done_q   <= 1'b1;
          end else if (rd_rfault) state_q <= ST_RF_WR;
          else                    state_q <= ST_AN_WAIT;
        end
        ST_RF_WR:    if (op_done) state_q <= ST_AN_WAIT;
        ST_AN_WAIT:  if (tick)    state_q <= ST_AN_RD;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  phy_mgmt_port #(.AW(AW), .DW(DW)) i_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write), .go_addr(go_addr),
    .go_wdata(go_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .op_done(op_done)
  );

  phy_adv_map #(.DW(DW)) i_adv (.abil(caps_q), .adv_word(adv_word));

  phy_poll_ctr #(.LIMIT(RST_POLLS)) i_rst_ctr (
    .clk(clk), .rst_n(rst_n), .clr(begin_run), .inc(rst_inc), .last(rst_last)
  );

  phy_poll_ctr #(.LIMIT(AN_POLLS)) i_an_ctr (
    .clk(clk), .rst_n(rst_n), .clr(begin_run), .inc(an_inc), .last(an_last)
  );

  assign done    = done_q;
  assign failed  = failed_q;
  assign timeout = tmo_q;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          done,
  input logic          failed,
  input logic          timeout
);
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata));

  a_r2_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed) || $rose(timeout) |-> done);

  a_r12_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(failed) || $fell(timeout) |-> $past(start));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(failed && timeout));

  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .done(done), .failed(failed), .timeout(timeout)
);

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
  localparam int AW = 5;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [DW-1:0] rsp_rdata = '0;
  logic req_valid, req_write, done, failed, timeout;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;

  always #10 clk = ~clk;

  phy_bringup_seq i_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done(done), .failed(failed), .timeout(timeout)
  );

  // reference model outputs
  bit e_valid = 0, e_write = 0, e_done = 0, e_failed = 0, e_tmo = 0;
  int e_addr = 0, e_wdata = 0;
  string tag = "R1";
  int vectors = 0, miscompares = 0, cycles = 0, runs = 0;

  // responder knobs and state
  int rl = 0, sl = 0, tp = 5;
  bit stray = 0;
  logic [15:0] rq[$];
  int rdy_cnt = 0, rsp_cnt = 0;
  bit rsp_pend = 0, acc_wr = 0;

  function automatic logic [15:0] adv_of(logic [15:0] c);
    return 16'h0001 | {6'b0, c[15], c[14], c[13], c[12], c[11], 5'b0};
  endfunction

  task automatic chk(string field, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", tag, field, got, exp, cycles);
    end
  endtask

  // one management operation as seen from the ports (R2)
  task automatic m_op(bit wr, int addr, int data, output logic [15:0] rdv);
    rdv = '0;
    @(posedge clk);
    e_valid = 1; e_write = wr; e_addr = addr; e_wdata = wr ? data : 0;
    do @(posedge clk); while (req_ready !== 1'b1);
    e_valid = 0;
    if (!wr) begin
      do @(posedge clk); while (rsp_valid !== 1'b1);
      rdv = rsp_rdata;
    end
  endtask

  task automatic m_wait_tick();
    tag = "R11";
    do @(posedge clk); while (tick !== 1'b1);
  endtask

  task automatic m_seq();
    logic [15:0] r, caps;
    tag = "R1";
    m_op(1, 0, 16'h8000, r);
    for (int k = 0; k < 6; k++) begin
      tag = "R3";
      m_op(0, 0, 0, r);
      if (!r[15]) break;
      if (k == 5) begin
        tag = "R4"; e_tmo = 1; e_done = 1;
        return;
      end
      m_wait_tick();
    end
    tag = "R5";
    m_op(1, 18, 16'hFFFF, r);
    m_op(0, 1, 0, caps);
    tag = "R6";
    m_op(1, 4, adv_of(caps), r);
    tag = "R7";
    m_op(1, 0, 16'h1200, r);
    for (int k = 0; k < 20; k++) begin
      tag = "R8";
      m_op(0, 1, 0, r);
      if (r[5]) begin
        e_failed = r[4]; e_done = 1;
        return;
      end
      if (k == 19) begin
        tag = "R10"; e_failed = 1; e_done = 1;
        return;
      end
      if (r[4]) begin
        tag = "R9";
        m_op(1, 0, 16'h3300, r);
      end
      m_wait_tick();
    end
  endtask

  // model thread: starts seen while busy are never looked at (R13)
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      if (e_done) tag = "R12";
      e_done = 0;
      if (start === 1'b1) begin
        tag = "R12"; e_failed = 0; e_tmo = 0;
        m_seq();
        runs++;
      end
    end
  end

  // compare every cycle, then drive the responder and tick
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
      chk("req_valid", req_valid, e_valid);
      chk("done", done, e_done);
      chk("failed", failed, e_failed);
      chk("timeout", timeout, e_tmo);
      if (e_valid) begin
        chk("req_write", req_write, e_write);
        chk("req_addr", req_addr, e_addr);
        chk("req_wdata", req_wdata, e_wdata);
      end
      rsp_valid = 1'b0;
      if (rst_n) begin
        if (req_ready) begin
          req_ready = 1'b0;
          rdy_cnt = rl;
          if (!acc_wr) begin rsp_pend = 1; rsp_cnt = sl; end
        end else if (req_valid) begin
          if (rdy_cnt == 0) begin req_ready = 1'b1; acc_wr = req_write; end
          else rdy_cnt--;
        end
        if (rsp_pend) begin
          if (rsp_cnt == 0) begin
            rsp_valid = 1'b1;
            rsp_rdata = (rq.size() > 0) ? rq.pop_front() : 16'h0000;
            rsp_pend = 0;
          end else rsp_cnt--;
        end else if (stray && req_valid && !req_ready) begin
          rsp_valid = 1'b1;   // R2: stray strobe before acceptance
          rsp_rdata = 16'hFFFF;
        end
      end
      tick = ((cycles % tp) == 0);
    end
  end

  task automatic run_scen(int rl_i, int sl_i, int tp_i, bit stray_i, bit poke_busy);
    int r0;
    rl = rl_i; sl = sl_i; tp = tp_i; stray = stray_i; rdy_cnt = rl_i;
    r0 = runs;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      // R13: start while busy
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait (runs == r0 + 1);
    repeat (4) @(negedge clk);
    tag = "R2";
    chk("responses left", rq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R1 reset state compared each cycle
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // S1: R3 R5 R6 R8 clean run, caps 100F/100H/10F/10H
    rq = '{16'h8000, 16'h0000, 16'h7800, 16'h0000, 16'h0020};
    run_scen(0, 0, 5, 0, 0);

    // S2: R4 reset timeout, slow master, stray strobes, R13 busy start
    rq = '{16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000};
    run_scen(2, 1, 4, 1, 1);

    // S3: R9 remote fault then completion, T4 only; R12 clears timeout
    rq = '{16'h0000, 16'h8000, 16'h0010, 16'h0000, 16'h0020};
    run_scen(1, 0, 3, 1, 0);

    // S4: R10 twenty polls without completion, all abilities
    rq = '{16'h0000, 16'hF800};
    for (int i = 0; i < 20; i++) rq.push_back((i == 19) ? 16'h0010 : 16'h0000);
    run_scen(0, 2, 6, 0, 0);

    // S5: R8 completion with remote fault still set gives failed
    rq = '{16'h0000, 16'h0000, 16'h0030};
    run_scen(3, 3, 7, 0, 0);

    // S6: R3 reset clears on the sixth read, 10 full/half only
    rq = '{16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h0000, 16'h1800, 16'h0020};
    run_scen(0, 1, 4, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule